// File: doc/BRIEF.md
# Multiplexed Video Memory Bus Sequencer

This block sits between rendering or host logic and an external video memory. On that memory's bus the low address byte and the data byte share one 8-bit path. Each accepted request becomes a fixed access lasting two pixel cycles, and each pixel cycle is split into two half-cycles. The block's clock runs at twice the pixel rate. A phase input marks which half of the pixel cycle is in progress.

In the first pixel cycle the shared bus carries the low address byte. A latch-enable strobe rises during the first half only, so that an external latch can capture that byte. In the second pixel cycle the access depends on its direction:

- A read releases the bus and holds the read strobe low, and the block captures the returned byte.
- A write keeps the bus driven with the write byte and holds the write strobe low.

Throughout the access, the upper address bits sit on their own pins.

Top module: `vmem_bus_seq`

## Requirements
- R1: An accepted access occupies exactly four half-cycles (two pixel cycles). With a request held continuously, a new access is acknowledged every four half-cycles.
- R2: `ale` is high only in the first half-cycle of an access, when `ph` is 0. In both half-cycles of the first pixel cycle, `bus_oe` is 1 and `bus_out` equals address bits 7:0.
- R3: For a read (`req_we`=0), `rd_n` is 0 and `bus_oe` is 0 for both half-cycles of the second pixel cycle, and `wr_n` stays 1.
- R4: For a write (`req_we`=1), `wr_n` is 0 for both half-cycles of the second pixel cycle, with `bus_oe`=1 and `bus_out` equal to the write byte. `rd_n` stays 1.
- R5: `addr_hi` equals address bits 13:8 for all four half-cycles of an access.
- R6: At the clock edge ending a read, `bus_in` is captured. In the following half-cycle, `rdata` holds that byte and `rvalid` is 1. `rvalid` is 1 for exactly one half-cycle and is never set by a write.
- R7: When no access is in progress, `ale`=0, `rd_n`=1, `wr_n`=1 and `bus_oe`=0.
- R8: A request is accepted only at an edge that ends a half-cycle with `ph`=1. `ack` is high for the single half-cycle in which the access starts. A request raised during a `ph`=0 half-cycle is acknowledged one half-cycle later than one raised during a `ph`=1 half-cycle.
- R9: `bus_oe` is never 1 while `rd_n` is 0, and `rd_n` and `wr_n` are never low together.
- R10: After reset, `ack`=0, `rvalid`=0, `addr_hi`=0 and the bus is idle as in R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-cycle clock, twice the pixel rate |
| rst_n | input | 1 | Active-low synchronous reset |
| ph | input | 1 | Current half of the pixel cycle (0 first, 1 second) |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 for write, 0 for read |
| req_addr | input | 14 | Access address |
| req_wdata | input | 8 | Write byte |
| ack | output | 1 | Access accepted, one half-cycle pulse |
| rdata | output | 8 | Captured read byte |
| rvalid | output | 1 | `rdata` updated, one half-cycle pulse |
| ale | output | 1 | Address latch enable, active high |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| addr_hi | output | 6 | Address bits 13:8 |
| bus_out | output | 8 | Shared bus output value |
| bus_oe | output | 1 | Shared bus driver enable |
| bus_in | input | 8 | Shared bus input value |

## Verification
The assertions assume that `ph` alternates on every clock edge, so that the first half after an accepted request has `ph`=0. The bench generates `ph` from its own clock loop, so this holds from reset onwards. Stimulus raises requests in both phases to exercise the acceptance rule. The bench acts as the external latch and memory: it takes the low byte while `ale` is high and returns a byte computed from the latched address while `rd_n` is low.

// File: rtl/vbs_pkg.sv
`timescale 1ns/1ps
package vbs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADR0 = 3'd1,
    ST_ADR1 = 3'd2,
    ST_DAT0 = 3'd3,
    ST_DAT1 = 3'd4
  } vbs_state_e;

  // Next half-cycle state; take means a request is accepted at this edge
  function automatic vbs_state_e next_half(vbs_state_e s, logic take);
    vbs_state_e n;
    case (s)
      ST_ADR0: n = ST_ADR1;
      ST_ADR1: n = ST_DAT0;
      ST_DAT0: n = ST_DAT1;
      default: n = take ? ST_ADR0 : ST_IDLE;
    endcase
    return n;
  endfunction

  function automatic logic in_addr_phase(vbs_state_e s);
    return (s == ST_ADR0) || (s == ST_ADR1);
  endfunction

  function automatic logic in_data_phase(vbs_state_e s);
    return (s == ST_DAT0) || (s == ST_DAT1);
  endfunction

endpackage

// File: rtl/vbs_sequencer.sv
`timescale 1ns/1ps
module vbs_sequencer
  import vbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ph,
  input  logic       req,
  output vbs_state_e state,
  output logic       accept,
  output logic       last_half,
  output logic       ack
);
  logic free_slot;

  // free when idle or finishing the last half of an access
  assign free_slot = (state == ST_IDLE) || (state == ST_DAT1);
  assign last_half = (state == ST_DAT1);
  // ph high means this edge closes a pixel cycle
  assign accept    = free_slot && ph && req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      ack   <= 1'b0;
    end else begin
      state <= next_half(state, accept);
      ack   <= accept;
    end
  end
endmodule

// File: rtl/vbs_req_latch.sv
`timescale 1ns/1ps
module vbs_req_latch #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              we_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [DATA_W-1:0] wdata_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      we_q    <= req_we;
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end
endmodule

// File: rtl/vbs_pin_drive.sv
`timescale 1ns/1ps
module vbs_pin_drive
  import vbs_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  vbs_state_e        state,
  input  logic              we_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] wdata_q,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe
);
  logic adr_ph, dat_ph;

  always_comb begin
    adr_ph  = in_addr_phase(state);
    dat_ph  = in_data_phase(state);
    ale     = (state == ST_ADR0);
    rd_n    = !(dat_ph && !we_q);
    wr_n    = !(dat_ph && we_q);
    bus_oe  = adr_ph || (dat_ph && we_q);
    bus_out = dat_ph ? wdata_q : addr_q[DATA_W-1:0];
    addr_hi = addr_q[ADDR_W-1:DATA_W];
  end
endmodule

// File: rtl/vbs_read_capture.sv
`timescale 1ns/1ps
module vbs_read_capture #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end else begin
      rvalid <= capture;
      if (capture) rdata <= bus_in;
    end
  end
endmodule

// File: rtl/vmem_bus_seq.sv
`timescale 1ns/1ps
module vmem_bus_seq
  import vbs_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8,
  localparam int HI_W = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ph,
  input  logic              req,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              ack,
  output logic [DATA_W-1:0] rdata,
  output logic              rvalid,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [HI_W-1:0]   addr_hi,
  output logic [DATA_W-1:0] bus_out,
  output logic              bus_oe,
  input  logic [DATA_W-1:0] bus_in
);
  vbs_state_e        state;
  logic              accept, last_half, read_done;
  logic              we_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;

  vbs_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .ph(ph), .req(req),
    .state(state), .accept(accept), .last_half(last_half), .ack(ack)
  );

  vbs_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
    .clk(clk), .rst_n(rst_n), .accept(accept), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .we_q(we_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  vbs_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
    .state(state), .we_q(we_q), .addr_q(addr_q), .wdata_q(wdata_q),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi),
    .bus_out(bus_out), .bus_oe(bus_oe)
  );

  // capture at the edge that closes the read strobe window
  assign read_done = last_half && !we_q;

  vbs_read_capture #(.DATA_W(DATA_W)) u_cap (
    .clk(clk), .rst_n(rst_n), .capture(read_done), .bus_in(bus_in),
    .rdata(rdata), .rvalid(rvalid)
  );
endmodule

// File: rtl/vbs_checker.sv
`timescale 1ns/1ps
module vbs_checker #(
  parameter int HI_W = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ph,
  input logic            ack,
  input logic            ale,
  input logic            rd_n,
  input logic            wr_n,
  input logic            bus_oe,
  input logic [HI_W-1:0] addr_hi,
  input logic            rvalid
);
  p_ale_first_half_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> (!ph && bus_oe));

  p_ale_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);

  p_rd_full_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rd_n) |=> !rd_n);

  p_wr_full_cycle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |=> !wr_n);

  p_hi_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> $stable(addr_hi));

  p_rvalid_after_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rvalid |-> ($past(!rd_n) && rd_n));

  p_ack_at_boundary_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> (ale && !ph));

  p_no_drive_on_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_n |-> !bus_oe);

  p_strobes_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!rd_n, !wr_n}) <= 1);
endmodule

bind vmem_bus_seq vbs_checker #(.HI_W(HI_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ph(ph), .ack(ack), .ale(ale),
  .rd_n(rd_n), .wr_n(wr_n), .bus_oe(bus_oe), .addr_hi(addr_hi),
  .rvalid(rvalid)
);

// File: tb/vmem_bus_seq_test.sv
`timescale 1ns/1ps
module vmem_bus_seq_test;
  logic        clk = 1'b0, rst_n = 1'b0, ph = 1'b1;
  logic        req = 1'b0, req_we = 1'b0;
  logic [13:0] req_addr = '0;
  logic [7:0]  req_wdata = '0, bus_in = '0;
  logic        ack, rvalid, ale, rd_n, wr_n, bus_oe;
  logic [7:0]  rdata, bus_out;
  logic [5:0]  addr_hi;
  int checks = 0, errors = 0;
  bit done = 0;

  vmem_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .ph(ph), .req(req), .req_we(req_we),
    .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
    .rvalid(rvalid), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .addr_hi(addr_hi),
    .bus_out(bus_out), .bus_oe(bus_oe), .bus_in(bus_in)
  );

  // 200 MHz; ph changes just after each rising edge
  initial forever begin
    #2.5 clk = 1'b1;
    #1   ph = ~ph;
    #1.5 clk = 1'b0;
  end

  // memory model contents
  function automatic logic [7:0] mem_val(logic [5:0] hi, logic [7:0] lo);
    return {lo[3:0], lo[7:4]} ^ {2'b10, hi};
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic chk_idle(string tag);
    chk(ale == 0, {tag, " ale"}, ale, 0);
    chk(rd_n == 1 && wr_n == 1, {tag, " strobes"}, {rd_n, wr_n}, 3);
    chk(bus_oe == 0, {tag, " oe"}, bus_oe, 0);
  endtask

  task automatic access(bit we, logic [13:0] a, logic [7:0] wd, bit arr_ph);
    int n;
    logic [7:0] lo;
    do @(negedge clk); while (ph != arr_ph);
    req = 1; req_we = we; req_addr = a; req_wdata = wd;
    n = 0;
    do begin
      @(negedge clk); n++;
      if (!ack) chk_idle("R7 waiting");
    end while (!ack && n < 10);
    chk(n == (arr_ph ? 1 : 2), "R8 ack latency", n, arr_ph ? 1 : 2);
    req = 0;
    // first half of address cycle
    chk(ale == 1 && ph == 0, "R2 ale first half", {ale, ph}, 2);
    chk(bus_oe == 1 && bus_out == a[7:0], "R2 addr drive", bus_out, a[7:0]);
    chk(addr_hi == a[13:8], "R5 hi A0", addr_hi, a[13:8]);
    lo = bus_out;
    @(negedge clk);
    chk(ale == 0, "R2 ale low second half", ale, 0);
    chk(ack == 0, "R8 ack one pulse", ack, 0);
    chk(bus_oe == 1 && bus_out == a[7:0], "R2 addr held", bus_out, a[7:0]);
    chk(rd_n == 1 && wr_n == 1, "R1 no strobe in addr cycle", {rd_n, wr_n}, 3);
    chk(addr_hi == a[13:8], "R5 hi A1", addr_hi, a[13:8]);
    for (int h = 0; h < 2; h++) begin
      @(negedge clk);
      if (we) begin
        chk(wr_n == 0 && rd_n == 1, "R4 strobes", {rd_n, wr_n}, 2);
        chk(bus_oe == 1 && bus_out == wd, "R4 data drive", bus_out, wd);
      end else begin
        chk(rd_n == 0 && wr_n == 1, "R3 strobes", {rd_n, wr_n}, 1);
        chk(bus_oe == 0, "R3 bus released", bus_oe, 0);
        chk(bus_oe == 0 || rd_n == 1, "R9 no drive on read", bus_oe, 0);
        bus_in = mem_val(addr_hi, lo);
      end
      chk(addr_hi == a[13:8], "R5 hi data cycle", addr_hi, a[13:8]);
      chk(ale == 0, "R2 no ale in data cycle", ale, 0);
    end
    @(negedge clk);
    bus_in = 8'h00;
    chk_idle("R1 R7 done after four halves");
    chk(rvalid == !we, "R6 rvalid", rvalid, !we);
    if (!we) chk(rdata == mem_val(a[13:8], a[7:0]), "R6 rdata", rdata,
                 mem_val(a[13:8], a[7:0]));
    @(negedge clk);
    chk(rvalid == 0, "R6 rvalid one pulse", rvalid, 0);
  endtask

  initial begin
    int acks, ales;
    repeat (4) @(negedge clk);
    chk(ack == 0 && rvalid == 0 && addr_hi == 0, "R10 reset outputs",
        {ack, rvalid, addr_hi}, 0);
    chk_idle("R10 reset bus");
    rst_n = 1;
    @(negedge clk);
    chk_idle("R7 idle after reset");
    for (int i = 0; i < 64; i++)
      access(1'b0, {i[5:0], 8'(i * 37 + 5)}, 8'h00, i[0]);
    for (int i = 0; i < 32; i++)
      access(1'b1, {6'(63 - i), 8'(i * 91 + 3)}, 8'(i * 13 + 1), ~i[0]);
    // back-to-back reads with request held high
    do @(negedge clk); while (ph != 1'b1);
    req = 1; req_we = 0; req_addr = 14'h2A5C;
    do @(negedge clk); while (!ack);
    acks = 0; ales = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      bus_in = mem_val(addr_hi, 8'h5C);
      if (ack) acks++;
      if (ale) ales++;
      if (rvalid) chk(rdata == mem_val(6'h2A, 8'h5C), "R6 back-to-back rdata",
                      rdata, mem_val(6'h2A, 8'h5C));
    end
    chk(acks == 10, "R1 R8 ack every four halves", acks, 10);
    chk(ales == 10, "R1 ale every four halves", ales, 10);
    req = 0;
    repeat (6) @(negedge clk);
    chk_idle("R7 idle at end");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule